// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a down-counting watchdog with two levels of escalation. While running, the counter decrements once per clock. When it reaches zero it reloads from a programmable load value and keeps counting. The first expiry raises an interrupt that the system is expected to treat as non-maskable. If software has not serviced that interrupt by the next expiry, the block raises a reset request, but only when the reset-enable bit is set.

Software services the watchdog by writing the clear register or by writing a new load value. Either one reloads the counter and drops the pending interrupt. A lock register guards the configuration. Writing the unlock key opens it. Writing any other value closes it, and while it is closed, writes to the load and control registers have no effect.

Top module: `wdog_escalator`

## Requirements
- R1: After rst_n is released: irq and rst_req are 0, the count and the load value are all ones, the control bits are 0, and the lock is open.
- R2: While control bit 0 (run) is 1 and the count is nonzero, the count falls by one on every clock. While run is 0, the count holds.
- R3: While running, a clock on which the count is zero and irq is clear sets irq and reloads the count from the load value.
- R4: While running, a clock on which the count is zero, irq is already set and control bit 1 (reset enable) is 1 sets rst_req. The count reloads. rst_req then stays at 1 until rst_n is asserted.
- R5: With reset enable at 0, a second expiry leaves rst_req at 0 and irq at 1, and the count reloads.
- R6: A write to address 2 (any data) clears irq and reloads the count from the load value. On the same clock it takes priority over an expiry, so a write that lands on the second expiry produces no reset request. The lock does not block it.
- R7: A write to address 0 while the lock is open sets both the load value and the count to the written data, and clears irq.
- R8: A write to address 3 of 0x1ACCE551 opens the lock, and a write of any other value closes it. A read of address 3 returns 1 while the lock is closed and 0 while it is open.
- R9: While the lock is closed, writes to addresses 0 and 1 change neither the load value, the count, the control bits nor irq.
- R10: bus_rdata returns the selected register without delay: address 0 gives the load value, address 1 gives the control bits in bits 1:0, address 2 gives the current count, and address 3 gives the lock status. A write to address 1 while the lock is open stores wdata bits 1:0 as the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register select: 0 load, 1 control, 2 clear/count, 3 lock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by bus_addr |
| irq | output | 1 | First-stage interrupt, intended as non-maskable |
| rst_req | output | 1 | Second-stage reset request, sticky until rst_n |

## Verification
Two events can land on the same clock: a service write (clear or load) and an expiry of the counter. The directed part of the bench counts clocks from a small load value so that the clear write arrives exactly on the clock where the count is zero and irq is already pending. It then checks that irq drops, the count reloads and rst_req stays low. The random phase uses loads of 0 to 12 and mostly idle cycles, so service writes meet expiries many times. A per-cycle model that applies service before expiry judges every one of these coincidences.

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int          CNT_W      = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam logic [1:0] A_LOAD = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;
  localparam logic [1:0] A_LOCK = 2'd3;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic [1:0]       ctrl_q;
  logic             locked_q;

  wire wr_load = bus_wr && bus_addr == A_LOAD && !locked_q;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL && !locked_q;
  wire wr_clr  = bus_wr && bus_addr == A_CLR;
  wire wr_lock = bus_wr && bus_addr == A_LOCK;
  wire running = ctrl_q[0];
  wire expired = cnt_q == '0;

  always_comb begin
    case (bus_addr)
      A_LOAD:  bus_rdata = 32'(load_q);
      A_CTRL:  bus_rdata = {30'd0, ctrl_q};
      A_CLR:   bus_rdata = 32'(cnt_q);
      default: bus_rdata = {31'd0, locked_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '1;
      cnt_q    <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
      irq      <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
      if (wr_lock) locked_q <= bus_wdata != UNLOCK_KEY;
      if (wr_load) begin
        load_q <= CNT_W'(bus_wdata);
        cnt_q  <= CNT_W'(bus_wdata);
        irq    <= 1'b0;
      end else if (wr_clr) begin
        cnt_q <= load_q;
        irq   <= 1'b0;
      end else if (running) begin
        if (expired) begin
          cnt_q <= load_q;
          if (!irq) irq <= 1'b1;
          else if (ctrl_q[1]) rst_req <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

module wdog_escalator_chk #(
  parameter int          CNT_W      = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq,
  input logic             rst_req,
  input logic             locked,
  input logic [1:0]       ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load
);
  p_count_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && cnt != '0 && !bus_wr |=> cnt == $past(cnt) - CNT_W'(1));

  p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt) == '0 && $past(ctrl[0]));

  p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_rst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq) && $past(ctrl[1]));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd2 |=> !irq);

  p_key_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd3 && bus_wdata == UNLOCK_KEY |=> !locked);

  p_locked_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked && bus_wr && bus_addr == 2'd0 |=> $stable(load));
endmodule

bind wdog_escalator wdog_escalator_chk #(.CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .rst_req(rst_req), .locked(locked_q),
  .ctrl(ctrl_q), .cnt(cnt_q), .load(load_q)
);

// File: tb/wdog_escalator_test.sv
module wdog_escalator_test;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, rst_req;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl;
  logic        m_irq, m_rst, m_lock;

  wdog_escalator uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_exp(logic [1:0] a);
    case (a)
      2'd0:    return m_load;
      2'd1:    return {30'd0, m_ctrl};
      2'd2:    return m_cnt;
      default: return {31'd0, m_lock};
    endcase
  endfunction

  task automatic compare(string tag);
    chk(tag, "irq", 32'(irq), 32'(m_irq));
    chk(tag, "rst_req", 32'(rst_req), 32'(m_rst));
    chk(tag, "rdata", bus_rdata, rd_exp(bus_addr));
  endtask

  task automatic model_upd(logic wr, logic [1:0] a, logic [31:0] d);
    logic [1:0] oc = m_ctrl;
    logic       ol = m_lock;
    if (wr && a == 2'd1 && !ol) m_ctrl = d[1:0];
    if (wr && a == 2'd3) m_lock = (d != KEY);
    if (wr && a == 2'd0 && !ol) begin
      m_load = d; m_cnt = d; m_irq = 1'b0;
    end else if (wr && a == 2'd2) begin
      m_cnt = m_load; m_irq = 1'b0;
    end else if (oc[0]) begin
      if (m_cnt == 0) begin
        m_cnt = m_load;
        if (m_irq) m_rst = m_rst | oc[1];
        else m_irq = 1'b1;
      end else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_load = '1; m_cnt = '1; m_ctrl = '0; m_irq = 0; m_rst = 0; m_lock = 0;
    compare(tag);
  endtask

  task automatic step(string tag, logic wr, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    model_upd(wr, a, d);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 2'd2, '0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset("R1");
    step("R1", 0, 2'd0, '0);
    step("R1", 0, 2'd1, '0);
    step("R1", 0, 2'd3, '0);
    step("R1", 0, 2'd2, '0);

    step("R7", 1, 2'd0, 32'd3);
    idle("R2", 2);
    step("R10", 1, 2'd1, 32'd1);
    idle("R3", 4);
    chk("R3", "irq after first expiry", 32'(irq), 32'd1);
    idle("R5", 5);
    chk("R5", "no reset with enable off", 32'(rst_req), 32'd0);
    step("R10", 1, 2'd1, 32'd3);
    idle("R4", 5);
    chk("R4", "reset after second expiry", 32'(rst_req), 32'd1);
    step("R6", 1, 2'd2, '0);
    chk("R4", "reset stays after clear", 32'(rst_req), 32'd1);

    do_reset("R4");
    step("R7", 1, 2'd0, 32'd2);
    step("R10", 1, 2'd1, 32'd3);
    idle("R3", 5);
    chk("R6", "count at zero with irq pending", bus_rdata, 32'd0);
    step("R6", 1, 2'd2, 32'hDEAD);
    chk("R6", "clear beats second expiry", 32'(rst_req), 32'd0);
    chk("R6", "irq cleared", 32'(irq), 32'd0);

    step("R8", 1, 2'd3, 32'd0);
    step("R8", 0, 2'd3, '0);
    chk("R8", "lock reads 1", bus_rdata, 32'd1);
    step("R9", 1, 2'd0, 32'd7);
    step("R9", 0, 2'd0, '0);
    chk("R9", "load unchanged", bus_rdata, 32'd2);
    step("R9", 1, 2'd1, 32'd0);
    step("R9", 0, 2'd1, '0);
    chk("R9", "ctrl unchanged", bus_rdata, 32'd3);
    step("R8", 1, 2'd3, KEY);
    step("R8", 0, 2'd3, '0);
    chk("R8", "lock reads 0", bus_rdata, 32'd0);
    step("R7", 1, 2'd0, 32'd7);

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 99);
      if (m_rst && op < 10) do_reset("R4");
      else if (op < 70) step("R2", 0, 2'($urandom_range(0, 3)), '0);
      else if (op < 78) step("R7", 1, 2'd0, $urandom_range(0, 12));
      else if (op < 84) step("R10", 1, 2'd1, $urandom);
      else if (op < 92) step("R6", 1, 2'd2, $urandom);
      else step("R8", 1, 2'd3, ($urandom_range(0, 1) == 1) ? KEY : $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule